// File: doc/BRIEF.md
# HDLC receive FIFO with block-release control

This block buffers the bytes of an HDLC-style receiver and hands them to a host in blocks. Bytes arrive one at a time on a valid/data/end-of-frame input and are written into a 64-byte ring. A 2-bit threshold setting chooses the block size. When a full block is waiting, the controller pulses a pool-full interrupt. When a frame's last byte is buffered, it pulses a message-end interrupt for the bytes that remain of that frame. The host then fetches the block byte by byte through a read port and issues a release command. The release frees the block's space and allows the next announcement.

A 12-bit frame length counter advances by the size of each announced block and is presented as an 8-bit low part and a 4-bit high part. The release command clears a number of low counter bits that depends on the threshold setting. After a message-end, the low bits therefore also give the size of the final block. The threshold may be rewritten at any time and takes effect from the next decision. Raising it in the middle of a frame makes the counter lose part of the length. Bytes that arrive while the ring is full are discarded and set a sticky overflow flag.

Top module: `hdlc_rxq_ctrl`

## Requirements
- R1: Threshold code 00, 01, 10 and 11 (cfg_wdata bits 1:0) select block sizes of 32, 16, 4 and 2 bytes. When at least one block of that size is buffered with no frame end inside it and no block is outstanding, irq_pool pulses for one cycle and exactly that many bytes form the block.
- R2: After reset the threshold setting is 00 and cfg_rdata reads 0. Only bits 1:0 of a write are stored, so cfg_rdata bits 7:2 always read 0 (writing 8'hFF reads back 8'h03).
- R3: A byte that arrives while 64 bytes are held is discarded and sets ovf_flag, which stays set until a one-cycle rxrst_cmd clears it.
- R4: When the frame-end byte lies within the first block-size bytes waiting, irq_msgend pulses and the block ends at that byte, holding 1 up to the block size bytes.
- R5: After one interrupt, no further interrupt is raised until rel_cmd is given. irq_pool and irq_msgend are never high together.
- R6: In the cycle an interrupt is high, {cnt_hi, cnt_lo} holds the frame's byte count so far: the earlier value plus the new block's size, wrapping at 12 bits. The count restarts from 0 for the first block after a message-end. Reset value is 0.
- R7: rel_cmd for an outstanding block clears low counter bits by the threshold then in force: bits 4..0 for 00, bits 3..0 for 01, bits 1..0 for 10 and bit 0 for 11.
- R8: A threshold write between an interrupt and its release is used by that release and by the next block decision. Raising 4 bytes to 32 bytes after a 4-byte pool block of a 10-byte frame gives a count of 0 after release and 6 at the message-end.
- R9: While a block is outstanding, rd_data shows its next unread byte in arrival order and each rd_en cycle advances one byte. rel_cmd with no block outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | This byte closes its frame |
| cfg_wr | input | 1 | Write strobe for the threshold setting |
| cfg_wdata | input | 8 | Threshold write data, code in bits 1:0 |
| cfg_rdata | output | 8 | Threshold readback |
| rd_en | input | 1 | Consume the byte on rd_data |
| rd_data | output | 8 | Next byte of the outstanding block |
| rel_cmd | input | 1 | Release the outstanding block |
| rxrst_cmd | input | 1 | Receiver reset command, clears overflow |
| irq_pool | output | 1 | Pool-full interrupt pulse |
| irq_msgend | output | 1 | Message-end interrupt pulse |
| cnt_lo | output | 8 | Byte count, low part |
| cnt_hi | output | 4 | Byte count, high part |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench tests frames whose length is one byte, exactly one block, one byte over a block, and longer than the ring, and it changes the block size while idle. A design that placed the frame-end cut wrongly would split or merge those blocks. A design with a wrong restart or carry rule would show the wrong count, which the 300-byte frame exposes in the high part. One test raises the threshold mid-frame and expects the counter to lose bits at the release. A design that applied the old mask would keep a count of 4. The overflow test fills the ring with the host idle, expects exactly two 32-byte blocks, and then sends a short frame. A design that stored the extra bytes would return stale data and a longer final block.

// File: rtl/hdlc_rxq_pkg.sv
// Shared types and helpers for the HDLC receive FIFO controller.
// Assumes the block sizes are fixed at 32/16/4/2 bytes by the threshold code.
package hdlc_rxq_pkg;
    localparam int MAX_BLK = 32;
    localparam int BLK_W   = 6;
    localparam int MASK_W  = 5;

    typedef enum logic [1:0] {
        THR_32 = 2'b00,
        THR_16 = 2'b01,
        THR_4  = 2'b10,
        THR_2  = 2'b11
    } thr_code_e;

    // Block size in bytes selected by a threshold code.
    function automatic logic [BLK_W-1:0] blk_size(input thr_code_e code);
        case (code)
            THR_32:  blk_size = 6'd32;
            THR_16:  blk_size = 6'd16;
            THR_4:   blk_size = 6'd4;
            default: blk_size = 6'd2;
        endcase
    endfunction

    // Counter bits cleared by a release under a threshold code.
    function automatic logic [MASK_W-1:0] clr_mask(input thr_code_e code);
        case (code)
            THR_32:  clr_mask = 5'h1F;
            THR_16:  clr_mask = 5'h0F;
            THR_4:   clr_mask = 5'h03;
            default: clr_mask = 5'h01;
        endcase
    endfunction
endpackage

// File: rtl/hdlc_rxq_store.sv
// Ring storage for received bytes with a frame-end flag per entry.
// One write port, one combinational read port, and all frame-end flags
// exposed as a vector for the scanner. Assumes DEPTH is a power of two.
module hdlc_rxq_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_eof,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [DEPTH-1:0] eof_vec
);
    logic [DW-1:0] mem_q [DEPTH];

    // Write the addressed entry and its frame-end flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i]   <= '0;
                eof_vec[i] <= 1'b0;
            end
        end else if (wr_en) begin
            mem_q[wr_addr]   <= wr_data;
            eof_vec[wr_addr] <= wr_eof;
        end
    end

    // Present the entry at the read address.
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/hdlc_rxq_eofscan.sv
// Finds the first frame-end flag among the buffered entries that follow the
// block base. It looks no further than the block size or the occupancy,
// whichever is smaller. Purely combinational, so the depth grows with MAXB.
module hdlc_rxq_eofscan
    import hdlc_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int MAXB  = MAX_BLK,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] eof_vec,
    input  logic [AW-1:0]    base,
    input  logic [AW:0]      occ,
    input  logic [BLK_W-1:0] limit,
    output logic             found,
    output logic [BLK_W-1:0] offset
);
    logic [AW-1:0] idx;

    // Priority search for the nearest frame end inside the window.
    always_comb begin
        found  = 1'b0;
        offset = '0;
        idx    = '0;
        for (int i = 0; i < MAXB; i++) begin
            idx = base + AW'(i);
            if (!found && (BLK_W'(i) < limit) && ((AW+1)'(i) < occ) && eof_vec[idx]) begin
                found  = 1'b1;
                offset = BLK_W'(i);
            end
        end
    end
endmodule

// File: rtl/hdlc_rxq_bytecnt.sv
// Frame byte counter. It adds each announced block's size, restarts at a new
// frame, and clears masked low bits on a release. Assumes an add and a clear
// never happen in the same cycle.
module hdlc_rxq_bytecnt
    import hdlc_rxq_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int LO_W  = 8,
    localparam int HI_W = CNT_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic              restart,
    input  logic [BLK_W-1:0]  amount,
    input  logic              clr_en,
    input  logic [MASK_W-1:0] mask,
    output logic [LO_W-1:0]   cnt_lo,
    output logic [HI_W-1:0]   cnt_hi
);
    logic [CNT_W-1:0] cnt_q;

    // Accumulate block sizes or clear the masked low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (add_en)
            cnt_q <= (restart ? '0 : cnt_q) + CNT_W'(amount);
        else if (clr_en)
            cnt_q <= cnt_q & ~CNT_W'(mask);
    end

    assign cnt_lo = cnt_q[LO_W-1:0];
    assign cnt_hi = cnt_q[CNT_W-1:LO_W];
endmodule

// File: rtl/hdlc_rxq_ctrl.sv
// HDLC receive FIFO block-release controller (top).
// Buffers received bytes in a ring and announces one block at a time, either
// as a pool-full or a message-end. It holds the block until the host releases
// it, and keeps the frame byte count. Assumes DEPTH >= 2*MAX_BLK and
// a power of two.
module hdlc_rxq_ctrl
    import hdlc_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int REG_W = 8,
    parameter int CNT_W = 12,
    parameter int LO_W  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int HI_W = CNT_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_eof,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             rd_en,
    output logic [DW-1:0]    rd_data,
    input  logic             rel_cmd,
    input  logic             rxrst_cmd,
    output logic             irq_pool,
    output logic             irq_msgend,
    output logic [LO_W-1:0]  cnt_lo,
    output logic [HI_W-1:0]  cnt_hi,
    output logic             ovf_flag
);
    thr_code_e        thr_q;
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    base_ptr;
    logic [AW:0]      occ;
    logic             pending;
    logic [BLK_W-1:0] blk_len;
    logic [BLK_W-1:0] rd_off;
    logic             new_frame;

    logic             full;
    logic             accept;
    logic             rel_fire;
    logic [BLK_W-1:0] blk_sz;
    logic             scan_found;
    logic [BLK_W-1:0] scan_off;
    logic             me_go;
    logic             pf_go;
    logic [BLK_W-1:0] go_len;
    logic [AW-1:0]    rd_addr;
    logic [DEPTH-1:0] eof_vec;

    assign full     = (occ == (AW+1)'(DEPTH));
    assign accept   = rx_valid && !full;
    assign rel_fire = rel_cmd && pending;
    assign blk_sz   = blk_size(thr_q);
    assign me_go    = !pending && scan_found;
    assign pf_go    = !pending && !scan_found && (occ >= (AW+1)'(blk_sz));
    assign go_len   = me_go ? (scan_off + BLK_W'(1)) : blk_sz;
    assign rd_addr  = base_ptr + AW'(rd_off);
    assign cfg_rdata = {{(REG_W-2){1'b0}}, thr_q};

    hdlc_rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_addr (wr_ptr),
        .wr_data (rx_data),
        .wr_eof  (rx_eof),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .eof_vec (eof_vec)
    );

    hdlc_rxq_eofscan #(.DEPTH(DEPTH), .MAXB(MAX_BLK)) u_scan (
        .eof_vec (eof_vec),
        .base    (base_ptr),
        .occ     (occ),
        .limit   (blk_sz),
        .found   (scan_found),
        .offset  (scan_off)
    );

    hdlc_rxq_bytecnt #(.CNT_W(CNT_W), .LO_W(LO_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (me_go || pf_go),
        .restart (new_frame),
        .amount  (go_len),
        .clr_en  (rel_fire),
        .mask    (clr_mask(thr_q)),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi)
    );

    // Threshold setting: keep only the code bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= THR_32;
        else if (cfg_wr)
            thr_q <= thr_code_e'(cfg_wdata[1:0]);
    end

    // Advance the write pointer for each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (accept)
            wr_ptr <= wr_ptr + AW'(1);
    end

    // Occupancy: add accepted bytes, subtract a released block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= '0;
        else
            occ <= occ + (AW+1)'(accept) - (rel_fire ? (AW+1)'(blk_len) : '0);
    end

    // Block state: announce, hold until release, then free the space.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_ptr <= '0;
            pending  <= 1'b0;
            blk_len  <= '0;
            rd_off   <= '0;
        end else if (rel_fire) begin
            base_ptr <= base_ptr + AW'(blk_len);
            pending  <= 1'b0;
            rd_off   <= '0;
        end else begin
            if (me_go || pf_go) begin
                pending <= 1'b1;
                blk_len <= go_len;
            end
            if (rd_en && pending && (rd_off < blk_len))
                rd_off <= rd_off + BLK_W'(1);
        end
    end

    // Interrupt pulses, one cycle after the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pool   <= 1'b0;
            irq_msgend <= 1'b0;
        end else begin
            irq_pool   <= pf_go;
            irq_msgend <= me_go;
        end
    end

    // Mark that the next announcement starts a fresh frame count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            new_frame <= 1'b1;
        else if (me_go)
            new_frame <= 1'b1;
        else if (pf_go)
            new_frame <= 1'b0;
    end

    // Sticky overflow: set on a dropped byte, cleared by receiver reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (rxrst_cmd)
            ovf_flag <= 1'b0;
        else if (rx_valid && full)
            ovf_flag <= 1'b1;
    end
endmodule

// File: rtl/hdlc_rxq_ctrl_chk.sv
// Property checker for hdlc_rxq_ctrl, attached by bind. It observes ports
// and the block-outstanding and ring-full state of the top.
module hdlc_rxq_ctrl_chk
    import hdlc_rxq_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int LO_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rel_cmd,
    input logic             rxrst_cmd,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             irq_pool,
    input logic             irq_msgend,
    input logic [LO_W-1:0]  cnt_lo,
    input logic             ovf_flag,
    input logic             pending,
    input logic             full,
    input logic [1:0]       thr_q
);
    p_irq_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pool && irq_msgend));

    p_one_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !rel_cmd) |=> !(irq_pool || irq_msgend));

    p_irq_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pool || irq_msgend) |-> pending);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && full && !rxrst_cmd) |=> ovf_flag);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !rxrst_cmd) |=> ovf_flag);

    p_ovf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rxrst_cmd |=> !ovf_flag);

    p_cfg_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:2] == '0);

    p_release_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_cmd && pending) |=>
            ((cnt_lo[MASK_W-1:0] & clr_mask(thr_code_e'($past(thr_q)))) == '0));
endmodule

bind hdlc_rxq_ctrl hdlc_rxq_ctrl_chk #(.REG_W(REG_W), .LO_W(LO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rel_cmd    (rel_cmd),
    .rxrst_cmd  (rxrst_cmd),
    .cfg_rdata  (cfg_rdata),
    .irq_pool   (irq_pool),
    .irq_msgend (irq_msgend),
    .cnt_lo     (cnt_lo),
    .ovf_flag   (ovf_flag),
    .pending    (pending),
    .full       (full),
    .thr_q      (thr_q)
);

// File: tb/hdlc_rxq_ctrl_bench.sv
// Scoreboard bench: driver tasks queue expected blocks and bytes, and a
// monitor process services each interrupt and compares against the queues.
module hdlc_rxq_ctrl_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_eof = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rel_cmd = 1'b0;
    logic       rxrst_cmd = 1'b0;
    logic       irq_pool;
    logic       irq_msgend;
    logic [7:0] cnt_lo;
    logic [3:0] cnt_hi;
    logic       ovf_flag;

    hdlc_rxq_ctrl u_hdlc_rxq_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rd_en(rd_en), .rd_data(rd_data),
        .rel_cmd(rel_cmd), .rxrst_cmd(rxrst_cmd), .irq_pool(irq_pool),
        .irq_msgend(irq_msgend), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .ovf_flag(ovf_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int kind;   // 0 pool-full, 1 message-end
        int len;
        int cnt;
        int post;
        int hook;   // threshold code written before release, -1 for none
    } evt_t;

    evt_t      eq[$];
    logic [7:0] dq[$];
    int n_chk = 0;
    int n_err = 0;
    int cur_thr = 0;
    bit host_en = 1'b1;
    int irq_seen = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int bsz(input int code);
        case (code)
            0: return 32;
            1: return 16;
            2: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic int bmask(input int code);
        case (code)
            0: return 31;
            1: return 15;
            2: return 3;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] dbyte(input int seed, input int i);
        return 8'((seed + i * 7) & 255);
    endfunction

    function automatic int cnt12();
        return int'({cnt_hi, cnt_lo});
    endfunction

    task automatic drive(input int len, input int seed, input int gap, input bit with_eof);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = dbyte(seed, i);
            rx_eof   = with_eof && (i == len - 1);
            @(negedge clk);
            rx_valid = 1'b0;
            rx_eof   = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    // Queue the expected blocks of one frame under the current threshold, then send it.
    task automatic send_frame(input int len, input int seed);
        int b, m, nf, rem;
        evt_t e;
        b = bsz(cur_thr);
        m = bmask(cur_thr);
        for (int i = 0; i < len; i++) dq.push_back(dbyte(seed, i));
        nf  = (len - 1) / b;
        rem = len - nf * b;
        for (int j = 1; j <= nf; j++) begin
            e.kind = 0; e.len = b; e.cnt = (j * b) & 4095;
            e.post = e.cnt & ~m; e.hook = -1;
            eq.push_back(e);
        end
        e.kind = 1; e.len = rem; e.cnt = len & 4095;
        e.post = e.cnt & ~m; e.hook = -1;
        eq.push_back(e);
        drive(len, seed, 4, 1'b1);
    endtask

    task automatic set_thr(input int val);
        cfg_wr = 1'b1;
        cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_wr = 1'b0;
        cur_thr = val & 3;
    endtask

    task automatic wait_idle();
        while (eq.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic read_block(input int len);
        for (int k = 0; k < len; k++) begin
            chk(dq.size() != 0 && rd_data == dq[0], "R9 block byte order", int'(rd_data),
                dq.size() != 0 ? int'(dq[0]) : -1);
            if (dq.size() != 0) void'(dq.pop_front());
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic release_blk();
        rel_cmd = 1'b1;
        @(negedge clk);
        rel_cmd = 1'b0;
    endtask

    // Monitor: service each interrupt against the expected-block queue.
    initial begin
        evt_t e;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (irq_pool || irq_msgend) begin
                if (!host_en) begin
                    irq_seen++;
                end else if (eq.size() == 0) begin
                    chk(1'b0, "R5 unexpected interrupt", 1, 0);
                end else begin
                    e = eq.pop_front();
                    if (e.kind == 0)
                        chk(irq_pool && !irq_msgend, "R1 pool-full kind", int'(irq_pool), 1);
                    else
                        chk(irq_msgend && !irq_pool, "R4 message-end kind", int'(irq_msgend), 1);
                    if (e.hook >= 0 || e.cnt != e.post)
                        chk(cnt12() == e.cnt, "R8 count at interrupt", cnt12(), e.cnt);
                    else
                        chk(cnt12() == e.cnt, "R6 count at interrupt", cnt12(), e.cnt);
                    read_block(e.len);
                    if (e.hook >= 0) set_thr(e.hook);
                    release_blk();
                    chk(cnt12() == e.post, "R7 count after release", cnt12(), e.post);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (R9 run completion): actual timeout expected finish");
        finish_run();
    end

    initial begin
        evt_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 8'h00, "R2 threshold reset value", int'(cfg_rdata), 0);
        chk(cnt12() == 0, "R6 count reset value", cnt12(), 0);
        chk(ovf_flag == 1'b0, "R3 overflow reset value", int'(ovf_flag), 0);
        chk(!irq_pool && !irq_msgend, "R5 no interrupt after reset",
            int'({irq_pool, irq_msgend}), 0);

        set_thr(8'hFF);
        chk(cfg_rdata == 8'h03, "R2 unused bits read zero", int'(cfg_rdata), 3);
        set_thr(0);
        chk(cfg_rdata == 8'h00, "R2 code readback", int'(cfg_rdata), 0);

        // Release with nothing outstanding is ignored.
        release_blk();
        chk(cnt12() == 0 && !irq_pool && !irq_msgend, "R9 idle release ignored", cnt12(), 0);

        // 32-byte blocks: minimal, exact, one over, long frame.
        send_frame(1, 10);
        send_frame(32, 20);
        send_frame(33, 30);
        send_frame(300, 40);
        wait_idle();

        set_thr(1);
        send_frame(20, 50);
        send_frame(16, 60);
        wait_idle();

        set_thr(2);
        send_frame(9, 70);
        send_frame(3, 80);
        wait_idle();

        set_thr(3);
        send_frame(5, 90);
        send_frame(1, 100);
        wait_idle();

        // R8: raise the threshold from 4 to 32 bytes after the first pool block.
        set_thr(2);
        for (int i = 0; i < 10; i++) dq.push_back(dbyte(110, i));
        e.kind = 0; e.len = 4; e.cnt = 4; e.post = 0; e.hook = 0;
        eq.push_back(e);
        e.kind = 1; e.len = 6; e.cnt = 6; e.post = 0; e.hook = -1;
        eq.push_back(e);
        drive(10, 110, 4, 1'b1);
        wait_idle();
        chk(cfg_rdata == 8'h00, "R8 raised threshold in force", int'(cfg_rdata), 0);

        // R3: fill the ring with the host idle; extra bytes are dropped.
        host_en = 1'b0;
        irq_seen = 0;
        for (int i = 0; i < 64; i++) dq.push_back(dbyte(120, i));
        drive(70, 120, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk(ovf_flag == 1'b1, "R3 overflow set on drop", int'(ovf_flag), 1);
        chk(irq_seen == 1, "R5 one interrupt while unreleased", irq_seen, 1);
        repeat (5) @(negedge clk);
        chk(ovf_flag == 1'b1, "R3 overflow sticky", int'(ovf_flag), 1);
        rxrst_cmd = 1'b1;
        @(negedge clk);
        rxrst_cmd = 1'b0;
        chk(ovf_flag == 1'b0, "R3 receiver reset clears overflow", int'(ovf_flag), 0);
        read_block(32);
        release_blk();
        while (irq_seen < 2) @(negedge clk);
        chk(cnt12() == 64, "R6 count continues across pool blocks", cnt12(), 64);
        read_block(32);
        release_blk();
        repeat (10) @(negedge clk);
        chk(irq_seen == 2, "R3 dropped bytes left no block", irq_seen, 2);

        // A short frame after the drops: only its own bytes, count keeps running.
        host_en = 1'b1;
        for (int i = 0; i < 3; i++) dq.push_back(dbyte(130, i));
        e.kind = 1; e.len = 3; e.cnt = 67; e.post = 64; e.hook = -1;
        eq.push_back(e);
        drive(3, 130, 4, 1'b1);
        wait_idle();
        chk(dq.size() == 0, "R9 all bytes consumed", dq.size(), 0);
        finish_run();
    end
endmodule